// File: doc/BRIEF.md
# Floating-point single-precision boxing and context-status tracker

This block sits between a 64-bit floating-point register file and the single-precision datapaths. On the write path it places a 32-bit result inside a 64-bit register word with every upper bit set to one. Double-precision writes pass through unchanged. On the read path it checks whether a 64-bit register word holds a correctly boxed single-precision value. If it does not, the block supplies the canonical single-precision quiet NaN in place of the malformed operand.

The block also holds the 2-bit floating-point context status field and its one-bit summary-dirty flag. Encodings: 0 = off, 1 = initial, 2 = clean, 3 = dirty. A register write taken while the field is initial or clean moves the field to dirty. When virtualization is enabled, the same write also marks a second, shadow copy of the status dirty. While the field is off, any floating-point access is flagged illegal and the register-file write enable stays low. A load port lets the surrounding control logic set either copy to any value.

Top module: `fp_box_ctx`

## Requirements
- R1: With wr_single_i = 1, wr_data_o equals {32'hFFFF_FFFF, wr_data_i[31:0]} in the same cycle.
- R2: With wr_single_i = 0, wr_data_o equals wr_data_i unchanged.
- R3: When rd_raw_i[63:32] is all ones, rd_op_o equals rd_raw_i[31:0] and rd_box_o equals rd_raw_i.
- R4: When any bit of rd_raw_i[63:32] is zero, rd_op_o is 32'h7FC0_0000 and rd_box_o is 64'hFFFF_FFFF_7FC0_0000.
- R5: After reset, ctx_o, shadow_ctx_o, sum_dirty_o and shadow_sum_dirty_o are all 0.
- R6: A cycle with ld_i = 1 loads ld_val_i into the primary copy (ld_shadow_i = 0) or the shadow copy (ld_shadow_i = 1) from the next cycle. The loaded copy's summary bit becomes 1 exactly when the value is 3. A load to the primary copy wins over a write in the same cycle.
- R7: A write (wr_valid_i = 1) while ctx_o is 1 or 2 sets ctx_o to 3 and sum_dirty_o to 1 from the next cycle.
- R8: If virt_en_i = 1 during such a write, shadow_ctx_o also becomes 3 and shadow_sum_dirty_o becomes 1 from the next cycle.
- R9: A write while ctx_o is already 3 changes nothing: ctx_o stays 3 and the shadow copy keeps its value, even when virt_en_i = 1.
- R10: While ctx_o is 0, illegal_o is 1 in any cycle with wr_valid_i or rd_valid_i high, wr_en_o is 0, and the write leaves ctx_o at 0.
- R11: A write with virt_en_i = 0 leaves the shadow copy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Floating-point register write request |
| wr_single_i | input | 1 | 1: single-precision result, 0: double |
| wr_data_i | input | 64 | Result to be written |
| wr_data_o | output | 64 | Register-file write data, boxed when single |
| wr_en_o | output | 1 | Register-file write enable |
| rd_valid_i | input | 1 | Floating-point operand read request |
| rd_raw_i | input | 64 | Raw register word |
| rd_op_o | output | 32 | Single-precision operand |
| rd_box_o | output | 64 | Boxed form of rd_op_o |
| virt_en_i | input | 1 | Virtualization enabled: also update shadow copy |
| ld_i | input | 1 | Load a status copy |
| ld_shadow_i | input | 1 | Load target: 0 primary, 1 shadow |
| ld_val_i | input | 2 | Value to load |
| ctx_o | output | 2 | Primary status field |
| sum_dirty_o | output | 1 | Primary summary-dirty bit |
| shadow_ctx_o | output | 2 | Shadow status field |
| shadow_sum_dirty_o | output | 1 | Shadow summary-dirty bit |
| illegal_o | output | 1 | Access attempted while status is off |

## Verification
Some properties are checked on every cycle. A qualifying write must leave the primary copy dirty, and the shadow copy dirty as well when virtualization is on. A dirty field stays dirty until it is reloaded. Each summary bit always agrees with its field. The enable and illegal outputs never claim access while the status is off, and the boxed read word always has its upper half set. Only the bench scenarios show the exact boxing and NaN substitution values, including the boundary word 0xFFFFFFFF_00000000. They also show load priority over a same-cycle write, and that an already-dirty write leaves the shadow copy alone.

// File: rtl/fp_box_pkg.sv
package fp_box_pkg;
  typedef enum logic [1:0] {
    CTX_OFF   = 2'd0,
    CTX_INIT  = 2'd1,
    CTX_CLEAN = 2'd2,
    CTX_DIRTY = 2'd3
  } ctx_e;
endpackage

// File: rtl/fp_nan_box.sv
module fp_nan_box #(
  parameter int unsigned FLEN = 64,
  parameter int unsigned SLEN = 32
) (
  input  logic            single_i,
  input  logic [FLEN-1:0] data_i,
  output logic [FLEN-1:0] data_o
);
  localparam int unsigned HI = FLEN - SLEN;

  always_comb begin
    data_o = data_i;
    if (single_i) data_o = {{HI{1'b1}}, data_i[SLEN-1:0]};
  end
endmodule

// File: rtl/fp_nan_unbox.sv
module fp_nan_unbox #(
  parameter int unsigned FLEN      = 64,
  parameter int unsigned SLEN      = 32,
  parameter logic [31:0] CANON_NAN = 32'h7FC0_0000
) (
  input  logic [FLEN-1:0] raw_i,
  output logic [SLEN-1:0] op_o,
  output logic [FLEN-1:0] box_o
);
  localparam int unsigned HI = FLEN - SLEN;

  logic boxed_ok;
  assign boxed_ok = &raw_i[FLEN-1:SLEN];
  assign op_o     = boxed_ok ? raw_i[SLEN-1:0] : CANON_NAN[SLEN-1:0];
  assign box_o    = {{HI{1'b1}}, op_o};
endmodule

// File: rtl/fp_ctx_track.sv
module fp_ctx_track
  import fp_box_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_i,
  input  logic [1:0] ld_val_i,
  input  logic       mark_i,
  output logic [1:0] ctx_o,
  output logic       sd_o
);
  ctx_e ctx_q;
  logic sd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_q <= CTX_OFF;
      sd_q  <= 1'b0;
    end else if (ld_i) begin
      ctx_q <= ctx_e'(ld_val_i);
      sd_q  <= (ld_val_i == 2'd3);
    end else if (mark_i) begin
      ctx_q <= CTX_DIRTY;
      sd_q  <= 1'b1;
    end
  end

  assign ctx_o = ctx_q;
  assign sd_o  = sd_q;

  // R7
  mark_sets_dirty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_i && !ld_i) |=> (ctx_o == 2'd3 && sd_o));

  // R9
  dirty_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_o == 2'd3 && !ld_i) |=> (ctx_o == 2'd3));

  // R6
  summary_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_o == (ctx_o == 2'd3));
endmodule

// File: rtl/fp_box_ctx.sv
module fp_box_ctx #(
  parameter int unsigned FLEN       = 64,
  parameter int unsigned SLEN       = 32,
  parameter logic [31:0] CANON_NAN  = 32'h7FC0_0000,
  parameter bit          HAS_SHADOW = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_valid_i,
  input  logic            wr_single_i,
  input  logic [FLEN-1:0] wr_data_i,
  output logic [FLEN-1:0] wr_data_o,
  output logic            wr_en_o,
  input  logic            rd_valid_i,
  input  logic [FLEN-1:0] rd_raw_i,
  output logic [SLEN-1:0] rd_op_o,
  output logic [FLEN-1:0] rd_box_o,
  input  logic            virt_en_i,
  input  logic            ld_i,
  input  logic            ld_shadow_i,
  input  logic [1:0]      ld_val_i,
  output logic [1:0]      ctx_o,
  output logic            sum_dirty_o,
  output logic [1:0]      shadow_ctx_o,
  output logic            shadow_sum_dirty_o,
  output logic            illegal_o
);
  localparam int unsigned HI = FLEN - SLEN;
  localparam logic [FLEN-1:0] BOX_FLOOR = {{HI{1'b1}}, {SLEN{1'b0}}};

  logic ctx_off, clean_or_init, mark_pri, mark_sh;

  assign ctx_off       = (ctx_o == 2'd0);
  assign clean_or_init = (ctx_o == 2'd1) || (ctx_o == 2'd2);
  assign wr_en_o       = wr_valid_i && !ctx_off;
  assign illegal_o     = (wr_valid_i || rd_valid_i) && ctx_off;
  assign mark_pri      = wr_valid_i && clean_or_init;
  assign mark_sh       = mark_pri && virt_en_i;

  fp_nan_box #(.FLEN(FLEN), .SLEN(SLEN)) i_box (
    .single_i (wr_single_i),
    .data_i   (wr_data_i),
    .data_o   (wr_data_o)
  );

  fp_nan_unbox #(.FLEN(FLEN), .SLEN(SLEN), .CANON_NAN(CANON_NAN)) i_unbox (
    .raw_i (rd_raw_i),
    .op_o  (rd_op_o),
    .box_o (rd_box_o)
  );

  fp_ctx_track i_pri (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (ld_i && !ld_shadow_i),
    .ld_val_i (ld_val_i),
    .mark_i   (mark_pri),
    .ctx_o    (ctx_o),
    .sd_o     (sum_dirty_o)
  );

  generate
    if (HAS_SHADOW) begin : g_shadow
      fp_ctx_track i_sh (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ld_i     (ld_i && ld_shadow_i),
        .ld_val_i (ld_val_i),
        .mark_i   (mark_sh),
        .ctx_o    (shadow_ctx_o),
        .sd_o     (shadow_sum_dirty_o)
      );
    end else begin : g_no_shadow
      assign shadow_ctx_o       = 2'd0;
      assign shadow_sum_dirty_o = 1'b0;
    end
  endgenerate

  // R10
  no_wr_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (ctx_o != 2'd0 && !illegal_o));

  // R10
  off_stays_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_o == 2'd0 && !ld_i) |=> (ctx_o == 2'd0));

  // R4
  rd_box_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_box_o >= BOX_FLOOR);

  // R8
  shadow_dirty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && virt_en_i && !ld_i && (ctx_o == 2'd1 || ctx_o == 2'd2))
      |=> (!HAS_SHADOW || (shadow_ctx_o == 2'd3 && shadow_sum_dirty_o)));

  // R11
  shadow_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!virt_en_i && !ld_i) |=> $stable(shadow_ctx_o));
endmodule

// File: tb/test_fp_box_ctx.sv
module test_fp_box_ctx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 0, wr_single_i = 0, rd_valid_i = 0;
  logic [63:0] wr_data_i = '0, rd_raw_i = '0;
  logic        virt_en_i = 0, ld_i = 0, ld_shadow_i = 0;
  logic [1:0]  ld_val_i = '0;
  logic [63:0] wr_data_o, rd_box_o;
  logic [31:0] rd_op_o;
  logic        wr_en_o, sum_dirty_o, shadow_sum_dirty_o, illegal_o;
  logic [1:0]  ctx_o, shadow_ctx_o;

  int errors = 0, checks = 0;

  always #4 clk_i = ~clk_i;

  fp_box_ctx i_fp_box_ctx (
    .clk_i, .rst_ni, .wr_valid_i, .wr_single_i, .wr_data_i, .wr_data_o, .wr_en_o,
    .rd_valid_i, .rd_raw_i, .rd_op_o, .rd_box_o, .virt_en_i, .ld_i, .ld_shadow_i,
    .ld_val_i, .ctx_o, .sum_dirty_o, .shadow_ctx_o, .shadow_sum_dirty_o, .illegal_o
  );

  // {single, wr_data, rd_raw, exp_wr, exp_op}
  localparam logic [224:0] VEC [6] = '{
    {1'b1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_3F80_0000, 64'hFFFF_FFFF_89AB_CDEF, 32'h3F80_0000},
    {1'b0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFE_3F80_0000, 64'h0123_4567_89AB_CDEF, 32'h7FC0_0000},
    {1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_0000_0000, 32'h7FC0_0000},
    {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0000},
    {1'b0, 64'h4009_21FB_5444_2D18, 64'h7FFF_FFFF_FFFF_FFFF, 64'h4009_21FB_5444_2D18, 32'h7FC0_0000},
    {1'b1, 64'h0000_0000_BF80_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_BF80_0000, 32'hFFFF_FFFF}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk_i);
    #2;
  endtask

  task automatic load(input logic sh, input logic [1:0] v);
    ld_i = 1; ld_shadow_i = sh; ld_val_i = v;
    tick();
    ld_i = 0; ld_shadow_i = 0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1;
    tick();
    // R5 reset state
    chk("R5", {62'd0, ctx_o}, 64'd0);
    chk("R5", {62'd0, shadow_ctx_o}, 64'd0);
    chk("R5", {62'd0, sum_dirty_o, shadow_sum_dirty_o}, 64'd0);

    // R10 access while off
    wr_valid_i = 1; #1;
    chk("R10", {62'd0, illegal_o, wr_en_o}, 64'd2);
    tick();
    wr_valid_i = 0;
    chk("R10", {62'd0, ctx_o}, 64'd0);
    rd_valid_i = 1; #1;
    chk("R10", {63'd0, illegal_o}, 64'd1);
    rd_valid_i = 0;

    // R1 R2 R3 R4 vector table
    for (int i = 0; i < 6; i++) begin
      wr_single_i = VEC[i][224];
      wr_data_i   = VEC[i][223:160];
      rd_raw_i    = VEC[i][159:96];
      #1;
      chk(wr_single_i ? "R1" : "R2", wr_data_o, VEC[i][95:32]);
      chk((&rd_raw_i[63:32]) ? "R3" : "R4", {32'd0, rd_op_o}, {32'd0, VEC[i][31:0]});
      chk((&rd_raw_i[63:32]) ? "R3" : "R4", rd_box_o, {32'hFFFF_FFFF, VEC[i][31:0]});
    end

    // R6 load primary initial
    load(1'b0, 2'd1);
    chk("R6", {62'd0, ctx_o}, 64'd1);
    chk("R6", {63'd0, sum_dirty_o}, 64'd0);

    // R7 R11 write from initial, no virtualization
    wr_valid_i = 1; #1;
    chk("R7", {62'd0, wr_en_o, illegal_o}, 64'd2);
    tick();
    wr_valid_i = 0;
    chk("R7", {61'd0, ctx_o, sum_dirty_o}, 64'd7);
    chk("R11", {61'd0, shadow_ctx_o, shadow_sum_dirty_o}, 64'd0);

    // R6 reload clean, shadow initial
    load(1'b0, 2'd2);
    chk("R6", {61'd0, ctx_o, sum_dirty_o}, 64'd4);
    load(1'b1, 2'd1);
    chk("R6", {62'd0, shadow_ctx_o}, 64'd1);

    // R8 write from clean with virtualization
    virt_en_i = 1; wr_valid_i = 1;
    tick();
    wr_valid_i = 0;
    chk("R8", {61'd0, ctx_o, sum_dirty_o}, 64'd7);
    chk("R8", {61'd0, shadow_ctx_o, shadow_sum_dirty_o}, 64'd7);

    // R9 already dirty: shadow untouched
    load(1'b1, 2'd2);
    wr_valid_i = 1;
    tick();
    wr_valid_i = 0; virt_en_i = 0;
    chk("R9", {61'd0, ctx_o, sum_dirty_o}, 64'd7);
    chk("R9", {61'd0, shadow_ctx_o, shadow_sum_dirty_o}, 64'd4);

    // R6 load beats same-cycle write
    wr_valid_i = 1;
    load(1'b0, 2'd1);
    wr_valid_i = 0;
    chk("R6", {61'd0, ctx_o, sum_dirty_o}, 64'd2);

    // R6 load dirty sets summary
    load(1'b0, 2'd3);
    chk("R6", {61'd0, ctx_o, sum_dirty_o}, 64'd7);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule